// File: doc/BRIEF.md
# Bank-Switching Wait-State Inserter

This block sits between a processor core's access requests and an external memory port. It adds one idle cycle in front of an access when the access might collide with the previous one on the external bus. There are three such cases. The first is a move into a different memory bank within the same address space. The second is a step from data space into program space. The third, which can be switched on or off, is a back-to-back read that changes between program and data space. The bank size is set by a 4-bit compare mask. The mask selects which of the four top address bits are compared, so a bank can be anything from 4K words to the whole 64K space.

A 16-bit control register sits at address 0x0029 on a simple register port. It holds the compare mask, the read-turnaround enable, two bus-holder enables that are only passed out as pins, and an external-bus-off request. When the bus-off request is set, the access in progress is allowed to finish. The memory outputs then go quiet, new requests are stalled, and an acknowledge reports that the bus is idle.

The control is a three-state machine:
- `ST_RUN` is normal issue.
- `ST_WAIT` is the inserted idle cycle, after which the held request is issued.
- `ST_OFF` is the bus-off state.

The transitions are:
- hazard: `ST_RUN`→`ST_WAIT`
- park: `ST_RUN`→`ST_OFF`
- resume: `ST_WAIT`→`ST_RUN`
- finish-then-park: `ST_WAIT`→`ST_OFF`
- wake: `ST_OFF`→`ST_RUN`

Top module: `bank_wait_inserter`

## Requirements
- R1: After reset, reading address 0x0029 returns 0xF800. Reading any other register address returns 0.
- R2: Register bits 10..3 always read 0, whatever is written to them. A write to any address other than 0x0029 leaves the register unchanged.
- R3: Register bit 2 drives `hpi_hold_en` and bit 1 drives `data_hold_en`. Both are written and read back directly.
- R4: The first access after reset gets one inserted cycle.
- R5: An access gets one inserted cycle when it is in the same space as the previous issued access and its address bits 15..12, ANDed with the mask in register bits 15..12, differ from those of that access. Space is encoded as 0 for data and 1 for program. A mask of 0 means no bank waits are added.
- R6: An access to program space that directly follows a data-space access gets one inserted cycle.
- R7: When register bit 11 is 1, a read that follows a read in the other space gets one inserted cycle (write = 1 marks a write). When bit 11 is 0, this rule adds nothing.
- R8: At most one cycle is inserted per access, and `req_ready` is low during it. `mem_valid` and `req_ready` are high together, and the issued access carries the request's address, space and write flag. When `mem_valid` is low, `mem_addr`, `mem_space` and `mem_write` are all 0.
- R9: Setting register bit 0 lets a pending inserted-cycle access issue first. After that, `bus_off_ack` goes high, requests are stalled, and the memory outputs stay 0. Clearing the bit resumes normal operation.
- R10: An access that matches none of R4 to R7 is issued in the cycle it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 16 | Register port address |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| req_valid | input | 1 | Core access request |
| req_space | input | 1 | 0 = data, 1 = program |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_ready | output | 1 | Request accepted this cycle |
| mem_valid | output | 1 | External access issued |
| mem_space | output | 1 | Issued space |
| mem_write | output | 1 | Issued write flag |
| mem_addr | output | 16 | Issued address |
| hpi_hold_en | output | 1 | Host-port bus-holder enable |
| data_hold_en | output | 1 | Data bus-holder enable |
| bus_off_ack | output | 1 | External bus parked |

## Verification
The assertions are checked on every cycle. They cover four things:
- Any issued access that is a first access, a bank crossing, a data-to-program step or an enabled read turnaround was preceded by the wait state.
- The wait state never lasts more than one cycle.
- The memory outputs are quiet when idle or parked.
- The reserved bits read 0.

The bench's scenarios show what the assertions cannot. They show that no cycle is added when none is due, that the per-access latency is exact across sweeps of mask and turnaround settings, and that the register values read back correctly. They also show the bus-off sequence: a pending access finishes before the bus parks.

// File: rtl/bws_pkg.sv
package bws_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WAIT = 2'd1,
        ST_OFF  = 2'd2
    } bws_state_e;

    localparam logic SPACE_DATA = 1'b0;
    localparam logic SPACE_PROG = 1'b1;
endpackage

// File: rtl/bws_ctrl_reg.sv
module bws_ctrl_reg #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 16,
    parameter int CMP_W    = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0029
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [CMP_W-1:0]  cmp_mask,
    output logic              turn_en,
    output logic              hpi_hold,
    output logic              data_hold,
    output logic              bus_off
);
    localparam int TURN_BIT = DATA_W - CMP_W - 1;
    localparam int RSV_W    = DATA_W - CMP_W - 4;

    logic hit;
    assign hit = (addr == REG_ADDR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_mask  <= '1;
            turn_en   <= 1'b1;
            hpi_hold  <= 1'b0;
            data_hold <= 1'b0;
            bus_off   <= 1'b0;
        end else if (wr_en && hit) begin
            cmp_mask  <= wdata[DATA_W-1 -: CMP_W];
            turn_en   <= wdata[TURN_BIT];
            hpi_hold  <= wdata[2];
            data_hold <= wdata[1];
            bus_off   <= wdata[0];
        end
    end

    always_comb begin
        if (hit) rdata = {cmp_mask, turn_en, {RSV_W{1'b0}}, hpi_hold, data_hold, bus_off};
        else     rdata = '0;
    end
endmodule

// File: rtl/bws_history.sv
module bws_history #(
    parameter int CMP_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [CMP_W-1:0] nib_in,
    input  logic             space_in,
    input  logic             read_in,
    output logic             prv_vld,
    output logic [CMP_W-1:0] prv_nib,
    output logic             prv_space,
    output logic             prv_read
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prv_vld   <= 1'b0;
            prv_nib   <= '0;
            prv_space <= 1'b0;
            prv_read  <= 1'b0;
        end else if (upd) begin
            prv_vld   <= 1'b1;
            prv_nib   <= nib_in;
            prv_space <= space_in;
            prv_read  <= read_in;
        end
    end
endmodule

// File: rtl/bws_hazard.sv
module bws_hazard
    import bws_pkg::*;
#(
    parameter int CMP_W = 4
) (
    input  logic             prv_vld,
    input  logic [CMP_W-1:0] prv_nib,
    input  logic             prv_space,
    input  logic             prv_read,
    input  logic [CMP_W-1:0] cur_nib,
    input  logic             cur_space,
    input  logic             cur_read,
    input  logic [CMP_W-1:0] cmp_mask,
    input  logic             turn_en,
    output logic             need_wait
);
    logic bank_cross, space_step, read_turn;

    always_comb begin
        bank_cross = (prv_space == cur_space) && (((prv_nib ^ cur_nib) & cmp_mask) != '0);
        space_step = (prv_space == SPACE_DATA) && (cur_space == SPACE_PROG);
        read_turn  = turn_en && prv_read && cur_read && (prv_space != cur_space);
        need_wait  = !prv_vld || bank_cross || space_step || read_turn;
    end
endmodule

// File: rtl/bank_wait_inserter.sv
module bank_wait_inserter
    import bws_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'h0029
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr_en,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              req_valid,
    input  logic              req_space,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_ready,
    output logic              mem_valid,
    output logic              mem_space,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              hpi_hold_en,
    output logic              data_hold_en,
    output logic              bus_off_ack
);
    localparam int NIB_LSB = ADDR_W - CMP_W;

    logic [CMP_W-1:0] cmp_mask;
    logic             turn_en;
    logic             bus_off;
    logic             prv_vld, prv_space, prv_read;
    logic [CMP_W-1:0] prv_nib;
    logic             need_wait;
    logic             issue;
    bws_state_e       state_q, state_d;

    bws_ctrl_reg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W), .REG_ADDR(REG_ADDR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr_en(reg_wr_en),
        .wdata(reg_wdata), .rdata(reg_rdata), .cmp_mask(cmp_mask),
        .turn_en(turn_en), .hpi_hold(hpi_hold_en), .data_hold(data_hold_en),
        .bus_off(bus_off)
    );

    bws_history #(.CMP_W(CMP_W)) u_hist (
        .clk(clk), .rst_n(rst_n), .upd(issue),
        .nib_in(req_addr[ADDR_W-1:NIB_LSB]), .space_in(req_space),
        .read_in(!req_write), .prv_vld(prv_vld), .prv_nib(prv_nib),
        .prv_space(prv_space), .prv_read(prv_read)
    );

    bws_hazard #(.CMP_W(CMP_W)) u_haz (
        .prv_vld(prv_vld), .prv_nib(prv_nib), .prv_space(prv_space),
        .prv_read(prv_read), .cur_nib(req_addr[ADDR_W-1:NIB_LSB]),
        .cur_space(req_space), .cur_read(!req_write), .cmp_mask(cmp_mask),
        .turn_en(turn_en), .need_wait(need_wait)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (bus_off)                     state_d = ST_OFF;
                else if (req_valid && need_wait) state_d = ST_WAIT;
            end
            ST_WAIT: state_d = bus_off ? ST_OFF : ST_RUN;
            ST_OFF:  if (!bus_off) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        issue = 1'b0;
        unique case (state_q)
            ST_RUN:  issue = req_valid && !bus_off && !need_wait;
            ST_WAIT: issue = req_valid;
            ST_OFF:  issue = 1'b0;
            default: issue = 1'b0;
        endcase
        req_ready   = issue;
        mem_valid   = issue;
        mem_space   = issue && req_space;
        mem_write   = issue && req_write;
        mem_addr    = issue ? req_addr : '0;
        bus_off_ack = (state_q == ST_OFF);
    end
endmodule

// File: rtl/bws_checker.sv
module bws_checker
    import bws_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int CMP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input bws_state_e        st,
    input logic [CMP_W-1:0]  mask,
    input logic              turn,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              mem_valid,
    input logic              mem_space,
    input logic              mem_write,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              bus_off_ack
);
    localparam int NIB_LSB = ADDR_W - CMP_W;
    localparam int RSV_HI  = DATA_W - CMP_W - 2;

    logic             lv, ls, lr;
    logic [CMP_W-1:0] ln;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lv <= 1'b0; ls <= 1'b0; lr <= 1'b0; ln <= '0;
        end else if (mem_valid) begin
            lv <= 1'b1; ls <= mem_space; lr <= !mem_write;
            ln <= mem_addr[ADDR_W-1:NIB_LSB];
        end
    end

    AST_FIRST_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !lv) |-> st == ST_WAIT); // R4
    AST_BANK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && lv && mem_space == ls &&
         ((mem_addr[ADDR_W-1:NIB_LSB] ^ ln) & mask) != '0) |-> st == ST_WAIT); // R5
    AST_XSPACE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && lv && ls == SPACE_DATA && mem_space == SPACE_PROG) |-> st == ST_WAIT); // R6
    AST_TURN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && lv && turn && lr && !mem_write && mem_space != ls) |-> st == ST_WAIT); // R7
    AST_WAIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |=> (st != ST_WAIT)); // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_valid |-> (mem_addr == '0 && !mem_space && !mem_write)); // R8
    AST_ISSUE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_valid && mem_addr == req_addr)); // R8
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_off_ack |-> (!mem_valid && !req_ready)); // R9
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[RSV_HI:3] == '0); // R2
endmodule

bind bank_wait_inserter bws_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CMP_W(CMP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st(state_q), .mask(cmp_mask), .turn(turn_en),
    .reg_rdata(reg_rdata), .req_ready(req_ready), .req_addr(req_addr),
    .mem_valid(mem_valid), .mem_space(mem_space), .mem_write(mem_write),
    .mem_addr(mem_addr), .bus_off_ack(bus_off_ack)
);

// File: tb/bank_wait_inserter_test.sv
`timescale 1ns/1ps
module bank_wait_inserter_test;
    localparam time CYC = 20ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] reg_addr = '0;
    logic        reg_wr_en = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        req_valid = 1'b0, req_space = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_ready, mem_valid, mem_space, mem_write;
    logic [15:0] mem_addr;
    logic        hpi_hold_en, data_hold_en, bus_off_ack;

    int n_chk = 0, n_err = 0;
    bit m_pv = 0, m_ps = 0, m_pr = 0;
    int m_pn = 0;
    int m_mask = 15;
    bit m_turn = 1;

    always #(CYC/2) clk = ~clk;

    bank_wait_inserter uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready), .mem_valid(mem_valid), .mem_space(mem_space),
        .mem_write(mem_write), .mem_addr(mem_addr), .hpi_hold_en(hpi_hold_en),
        .data_hold_en(data_hold_en), .bus_off_ack(bus_off_ack)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input int exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp[15:0], req, "register read", reg_rdata, exp);
    endtask

    task automatic do_access(input bit s, input bit w, input logic [15:0] a);
        int nib, cyc, exp_cyc;
        bit bank, step, turn, need;
        string tag;
        nib  = a[15:12];
        bank = m_pv && (m_ps == s) && (((m_pn ^ nib) & m_mask) != 0);
        step = m_pv && !m_ps && s;
        turn = m_pv && m_pr && !w && (m_ps != s);
        need = !m_pv || bank || step || (turn && m_turn);
        if (!m_pv)      tag = "R4";
        else if (bank)  tag = "R5";
        else if (step)  tag = "R6";
        else if (turn)  tag = "R7";
        else            tag = "R10";
        exp_cyc = need ? 2 : 1;
        @(negedge clk);
        req_valid = 1'b1; req_space = s; req_write = w; req_addr = a;
        cyc = 0;
        forever begin
            #1;
            cyc++;
            if (req_ready || cyc > 4) break;
            @(negedge clk);
        end
        chk(cyc == exp_cyc, tag, "access latency", cyc, exp_cyc);
        chk(mem_valid && mem_addr == a && mem_space == s && mem_write == w, "R8",
            "issued access", {mem_valid, mem_space, mem_write, mem_addr},
            {1'b1, s, w, a});
        m_pv = 1; m_ps = s; m_pr = !w; m_pn = nib;
    endtask

    initial begin
        #(CYC * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        int masks[5] = '{15, 8, 3, 0, 6};
        logic [31:0] x;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset value and unmapped address
        rd_chk(16'h0029, 16'hF800, "R1");
        rd_chk(16'h0028, 16'h0000, "R1");
        chk(!bus_off_ack && !mem_valid && !req_ready, "R1", "idle outputs",
            {bus_off_ack, mem_valid, req_ready}, 0);
        // R2 reserved bits and foreign writes
        wr_reg(16'h0029, 16'hFFFE);
        rd_chk(16'h0029, 16'hF806, "R2");
        // R3 holder enables follow bits 2 and 1
        chk(hpi_hold_en && data_hold_en, "R3", "holder enables set",
            {hpi_hold_en, data_hold_en}, 3);
        wr_reg(16'h0029, 16'hF804);
        chk(hpi_hold_en && !data_hold_en, "R3", "holder enables split",
            {hpi_hold_en, data_hold_en}, 2);
        wr_reg(16'h002A, 16'h0000);
        rd_chk(16'h0029, 16'hF804, "R2");
        wr_reg(16'h0029, 16'hF800);
        rd_chk(16'h0029, 16'hF800, "R2");

        // R4..R7, R10 sweep over mask and turnaround settings
        x = 32'h1234_5678;
        for (int t = 0; t < 2; t++) begin
            for (int mi = 0; mi < 5; mi++) begin
                m_mask = masks[mi];
                m_turn = (t == 0);
                wr_reg(16'h0029, {m_mask[3:0], m_turn, 11'b0});
                for (int k = 0; k < 300; k++) begin
                    x = x * 32'd1664525 + 32'd1013904223;
                    do_access(x[20], x[25] & x[26], {x[31:28], x[11:0]});
                end
            end
        end
        @(negedge clk);
        req_valid = 1'b0;

        // R9 park from run state
        m_mask = 15; m_turn = 1;
        wr_reg(16'h0029, 16'hF801);
        req_valid = 1'b1; req_space = 1'b0; req_write = 1'b0; req_addr = 16'h3000;
        #1;
        chk(!req_ready && !mem_valid, "R9", "no issue while parking",
            {req_ready, mem_valid}, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            chk(bus_off_ack && !req_ready && !mem_valid && mem_addr == 0, "R9",
                "parked stall", {bus_off_ack, req_ready, mem_valid, mem_addr}, 32'h4_0000);
        end
        req_valid = 1'b0;
        wr_reg(16'h0029, 16'hF800);
        @(negedge clk); #1;
        chk(!bus_off_ack, "R9", "wake from park", bus_off_ack, 0);
        do_access(1'b0, 1'b0, 16'h1000);

        // R9 pending inserted-cycle access completes before parking
        @(negedge clk);
        req_valid = 1'b1; req_space = 1'b1; req_write = 1'b0; req_addr = 16'h1004;
        reg_addr = 16'h0029; reg_wdata = 16'hF801; reg_wr_en = 1'b1;
        #1;
        chk(!req_ready, "R9", "inserted cycle before park", req_ready, 0);
        @(negedge clk);
        reg_wr_en = 1'b0;
        #1;
        chk(req_ready && mem_valid && mem_addr == 16'h1004, "R9", "pending access completes",
            {req_ready, mem_valid, mem_addr}, 32'h3_1004);
        m_pv = 1; m_ps = 1; m_pr = 1; m_pn = 1;
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(bus_off_ack && !mem_valid, "R9", "parked after completion",
            {bus_off_ack, mem_valid}, 2);
        wr_reg(16'h0029, 16'hF800);
        @(negedge clk); #1;
        chk(!bus_off_ack, "R9", "second wake", bus_off_ack, 0);
        do_access(1'b1, 1'b0, 16'h1FFF);
        do_access(1'b0, 1'b1, 16'h1000);
        do_access(1'b0, 1'b0, 16'hF000);
        @(negedge clk);
        req_valid = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule